// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Packed Per-Source Control Fields

This block collects up to 31 peripheral interrupt requests and turns them into a single 3-bit interrupt level for a processor. Each source has a 4-bit control field. The top bit of the field is the pending flag and the lower three bits are the priority. Eight fields share one 32-bit control word. A separate 32-bit trigger word selects, for each source, whether it is level-sensitive or latches on a rising edge.

Software reaches the control words and the trigger word through a simple register port. Writes to that port never read back the current value. On a control word, a write copies the priority bits of every field. It also treats a 1 in a pending position as a clear request. A handler can therefore clear one request by writing the word it read, with every pending bit but its own forced to 0.

When the processor strobes acknowledge, the block captures a vector number for the winning source: a fixed base of 64 plus the source number. If nothing is eligible, it returns the base itself as the spurious vector.

Top module: `nibble_intc`

## Requirements
- R1: After a synchronous reset the following are all zero: every pending flag, every priority, every trigger bit and `irq_level`. `ack_vector` reads 64.
- R2: Control words sit at addresses 0 to 3. Source n (1..31) uses word (n-1)/8, at bits [31-4*((n-1)%8) -: 4]. Field bit 3 is the pending flag and bits 2:0 are the priority. The unused last field of word 3 reads 0. `bus_rdata` is a combinational function of `bus_addr` and the current state.
- R3: A write to a control word loads every source priority in that word from bits 2:0 of its field. Priorities of sources in other words keep their values.
- R4: For an edge-triggered source, a write of 1 to its pending bit clears the flag. A write of 0 to that bit leaves the flag unchanged.
- R5: The trigger word is at address 4. Bit 31-(n-1) is 1 for edge and 0 for level on source n. Bit 0 reads 0.
- R6: A level-triggered source's pending flag equals its input from the previous clock. Writes to its pending bit have no effect on it.
- R7: An edge-triggered source sets its flag on a rising input edge and holds it after the input falls. A rising edge in the same cycle as a clear leaves the flag set.
- R8: `irq_level` is the highest priority among pending sources whose priority is nonzero. A source with priority 0 never raises it.
- R9: On `iack`, the next cycle's `ack_vector` is 64+n, where n is the winning source. Among equal priorities, the lowest source number wins.
- R10: On `iack` with no pending source of nonzero priority, the next `ack_vector` is 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 31 | Request inputs, bit n-1 is source n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| iack | input | 1 | Acknowledge strobe from the processor |
| irq_level | output | 3 | Current interrupt level to the processor |
| ack_vector | output | 8 | Vector captured at the last acknowledge |

## Verification
The bench builds the block with its default of 31 sources. With that count the fourth control word holds only seven fields, so both its empty eighth field and the spare low bit of the trigger word can be read and checked.

The 3-bit address reaches the four control words, the trigger word and three unmapped addresses. Writes to the unmapped addresses must leave all state alone.

The trigger mode of any source can be switched while its request is active. This lets the bench test mode changes, rising edges that coincide with clears, and ties between equal priorities against the model.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int REG_W    = 32;
    localparam int FIELD_W  = 4;
    localparam int PRIO_W   = FIELD_W - 1;
    localparam int SLOTS    = REG_W / FIELD_W;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 64;

    typedef struct packed {
        logic              pend;
        logic [PRIO_W-1:0] prio;
    } field_t;

    function automatic int slot_msb(input int k);
        return REG_W - 1 - FIELD_W * (k % SLOTS);
    endfunction
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
    import intc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   src,
    input  logic   edge_mode,
    input  logic   wr_en,
    input  field_t wr_field,
    output field_t field_q
);
    logic prev_q;
    logic rise;
    logic clr;

    assign rise = src & ~prev_q;
    assign clr  = wr_en & wr_field.pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            prev_q <= src;
            if (edge_mode)
                field_q.pend <= rise | (field_q.pend & ~clr);
            else
                field_q.pend <= src;
            if (wr_en)
                field_q.prio <= wr_field.prio;
        end
    end

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        !edge_mode |=> field_q.pend == $past(src)); // R6
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && field_q.pend && !(wr_en && wr_field.pend)) |=> field_q.pend); // R7
    AST_PRIO_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(field_q.prio)); // R3
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
    import intc_pkg::*;
#(
    parameter int NSRC  = 31,
    parameter int IDX_W = 5
) (
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0]           best_prio,
    output logic [IDX_W-1:0]            win_idx
);
    always_comb begin
        best_prio = '0;
        win_idx   = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (pend[k] && (prio[k] != '0) && (prio[k] >= best_prio)) begin
                best_prio = prio[k];
                win_idx   = IDX_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/nibble_intc.sv
module nibble_intc
    import intc_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              iack,
    output logic [PRIO_W-1:0] irq_level,
    output logic [VEC_W-1:0]  ack_vector
);
    localparam int NREG  = (NSRC + SLOTS - 1) / SLOTS;
    localparam int IDX_W = $clog2(NSRC + 1);
    localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(NREG);

    field_t                     fields [NSRC];
    logic [NSRC-1:0]            edge_q;
    logic [NSRC-1:0]            pend_v;
    logic [NSRC-1:0][PRIO_W-1:0] prio_v;
    logic [IDX_W-1:0]           win_idx;
    logic [PRIO_W-1:0]          win_prio;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        localparam int MSB = slot_msb(k);
        logic wr_hit;
        assign wr_hit = bus_we && (bus_addr == ADDR_W'(k / SLOTS));

        intc_src_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .src       (src_in[k]),
            .edge_mode (edge_q[k]),
            .wr_en     (wr_hit),
            .wr_field  (field_t'(bus_wdata[MSB -: FIELD_W])),
            .field_q   (fields[k])
        );
        assign pend_v[k] = fields[k].pend;
        assign prio_v[k] = fields[k].prio;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
        end else if (bus_we && bus_addr == TRIG_ADDR) begin
            for (int k = 0; k < NSRC; k++)
                edge_q[k] <= bus_wdata[REG_W-1-k];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == TRIG_ADDR) begin
            for (int k = 0; k < NSRC; k++)
                bus_rdata[REG_W-1-k] = edge_q[k];
        end else begin
            for (int k = 0; k < NSRC; k++)
                if (bus_addr == ADDR_W'(k / SLOTS))
                    bus_rdata[slot_msb(k) -: FIELD_W] = fields[k];
        end
    end

    intc_prio_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .pend      (pend_v),
        .prio      (prio_v),
        .best_prio (irq_level),
        .win_idx   (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ack_vector <= VEC_W'(VEC_BASE);
        else if (iack)
            ack_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end

    always_comb begin
        win_prio = '0;
        for (int k = 0; k < NSRC; k++)
            if (win_idx == IDX_W'(k + 1))
                win_prio = fields[k].prio;
    end

    AST_LEVEL_MATCHES_WINNER: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> (win_idx != '0 && win_prio == irq_level)); // R8
    AST_SPURIOUS_BASE: assert property (@(posedge clk) disable iff (rst)
        (iack && irq_level == '0) |=> ack_vector == VEC_W'(VEC_BASE)); // R10
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        iack |=> (ack_vector >= VEC_W'(VEC_BASE) && ack_vector <= VEC_W'(VEC_BASE + NSRC))); // R9
endmodule

// File: tb/nibble_intc_bench.sv
module nibble_intc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [30:0] src_in = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        iack = 1'b0;
    logic [2:0]  irq_level;
    logic [7:0]  ack_vector;

    int vectors = 0;
    int fails   = 0;
    string phase = "R1 reset";

    int m_pend [1:NS];
    int m_prio [1:NS];
    int m_edge [1:NS];
    int m_prev [1:NS];
    int m_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_intc u_nibble_intc (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .iack(iack), .irq_level(irq_level), .ack_vector(ack_vector)
    );

    function automatic int m_winner();
        int best = 0;
        int w = 0;
        for (int n = 1; n <= NS; n++)
            if (m_pend[n] != 0 && m_prio[n] > best) begin
                best = m_prio[n];
                w = n;
            end
        return w;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] r = '0;
        for (int n = 1; n <= NS; n++) begin
            if (a == 4)
                r[32-n] = (m_edge[n] != 0);
            else if (a == (n-1)/8) begin
                r[31-4*((n-1)%8)]      = (m_pend[n] != 0);
                r[30-4*((n-1)%8) -: 3] = 3'(m_prio[n]);
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int n = 1; n <= NS; n++) begin
                m_pend[n] = 0; m_prio[n] = 0; m_edge[n] = 0; m_prev[n] = 0;
            end
            m_vec = 64;
        end else begin
            int w;
            w = m_winner();
            if (iack) m_vec = 64 + w;
            for (int n = 1; n <= NS; n++) begin
                int s, hit, clr;
                s   = src_in[n-1];
                hit = (bus_we && int'(bus_addr) == (n-1)/8) ? 1 : 0;
                clr = (hit != 0 && bus_wdata[31-4*((n-1)%8)]) ? 1 : 0;
                if (m_edge[n] != 0) begin
                    if (s != 0 && m_prev[n] == 0) m_pend[n] = 1;
                    else if (clr != 0) m_pend[n] = 0;
                end else
                    m_pend[n] = s;
                m_prev[n] = s;
                if (hit != 0) m_prio[n] = int'(bus_wdata[30-4*((n-1)%8) -: 3]);
            end
            if (bus_we && bus_addr == 3'd4)
                for (int n = 1; n <= NS; n++) m_edge[n] = bus_wdata[32-n];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    task automatic compare();
        int w;
        w = m_winner();
        chk("R8 irq_level", 32'(irq_level), 32'(w == 0 ? 0 : m_prio[w]));
        chk(m_vec == 64 ? "R10 ack_vector" : "R9 ack_vector", 32'(ack_vector), 32'(m_vec));
        chk(bus_addr == 3'd4 ? "R5 rdata" : "R2 rdata", bus_rdata, m_read(int'(bus_addr)));
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                        input logic [30:0] s, input logic ack);
        @(negedge clk);
        compare();
        bus_we = we; bus_addr = a; bus_wdata = d; src_in = s; iack = ack;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired [%s] actual=hung expected=done", phase);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at ports
        @(negedge clk);
        chk("R1 irq_level", 32'(irq_level), 32'd0);
        chk("R1 ack_vector", 32'(ack_vector), 32'd64);
        for (int a = 0; a < 5; a++) begin
            bus_addr = 3'(a); #1;
            chk("R1 rdata", bus_rdata, 32'd0);
        end
        bus_addr = '0;
        phase = "R3 priority load";
        step(1, 3'd0, 32'h07654321, '0, 0);
        step(1, 3'd1, 32'h55550000, '0, 0);
        step(1, 3'd3, 32'hFFFFFFFF, '0, 0);
        step(0, 3'd3, '0, '0, 0);
        step(0, 3'd0, '0, '0, 0);
        phase = "R6 level follow";
        step(0, 3'd0, '0, 31'h6, 0);
        step(0, 3'd0, '0, 31'h6, 1);
        step(1, 3'd0, 32'h8F654321, 31'h6, 0);
        step(0, 3'd0, '0, 31'h0, 1);
        step(0, 3'd0, '0, 31'h0, 0);
        phase = "R5 trigger select";
        step(1, 3'd4, 32'hFF000001, '0, 0);
        step(0, 3'd4, '0, '0, 0);
        phase = "R7 edge latch";
        step(0, 3'd0, '0, 31'h10, 0);
        step(0, 3'd0, '0, 31'h00, 0);
        step(0, 3'd0, '0, 31'h00, 1);
        step(0, 3'd0, '0, 31'h01, 0);
        step(1, 3'd0, 32'h87654321, 31'h01, 0);
        step(1, 3'd0, 32'h87654321, 31'h00, 0);
        step(1, 3'd0, 32'h87654321, 31'h01, 0);
        step(0, 3'd0, '0, 31'h00, 0);
        phase = "R4 pending clear";
        step(1, 3'd0, 32'h07654321, '0, 0);
        step(1, 3'd0, 32'h00008000, '0, 0);
        step(1, 3'd0, 32'hF7654321, '0, 1);
        step(0, 3'd0, '0, '0, 0);
        phase = "R9 tie lowest";
        step(0, 3'd1, '0, 31'h0F00, 0);
        step(0, 3'd1, '0, 31'h0F00, 1);
        step(0, 3'd1, '0, 31'h0E00, 1);
        step(0, 3'd1, '0, 31'h0E00, 0);
        phase = "R10 spurious";
        step(0, 3'd2, '0, 31'h0, 0);
        step(0, 3'd2, '0, 31'h0, 1);
        step(0, 3'd2, '0, 31'h0, 0);
        phase = "R2 unmapped write";
        step(1, 3'd6, 32'hFFFFFFFF, '0, 0);
        step(0, 3'd3, '0, '0, 0);
        phase = "R8 mixed traffic";
        for (int i = 0; i < 3000; i++) begin
            logic [30:0] s;
            s = ($urandom % 4 == 0) ? 31'($urandom) : src_in;
            step(($urandom % 5) == 0, 3'($urandom % 8), $urandom, s, ($urandom % 3) == 0);
        end
        step(0, 3'd0, '0, '0, 0);
        finish_run();
    end
endmodule